// File: doc/BRIEF.md
# Round-Robin Central-Module Dispatcher

This block is the input stage of a three-stage packet switch. Every input port owns a small FIFO of fixed-size packets (one packet is one `PKT_W`-bit word). The number of central modules equals the number of input ports, and each central module is reached through one outgoing link. In every clock cycle (one time slot) each non-empty FIFO offers its head-of-line packet to the central module named by its own round-robin pointer. No request-grant matching runs across ports: each FIFO decides alone, and a port-level conflict is settled by a fixed priority.

Each outgoing link keeps a credit count for the first-hop buffer of its central module. A packet leaves only when that count is non-zero. A blocked FIFO keeps its packet and its pointer, and it tries the same central module again in the next slot. Dispatching new packets overlaps with the forwarding of earlier ones, so with credits available a port can send one packet every cycle.

The input side uses a valid/ready pair per port. `in_ready_o` is low while the FIFO is full. A write offered while ready is low is discarded and reported on `overflow_o`. The link side carries valid and data only. Back-pressure reaches it through `credit_ret_i`: one pulse returns one buffer slot.

Top module: `rr_cm_dispatch`

## Requirements
- R1: Packets written into one port's FIFO leave on the links in the order they were written, and no accepted packet is lost or duplicated.
- R2: After reset every port's pointer names central module 0. Each successful dispatch from a port moves that port's pointer to the next module, wrapping from `PORTS-1` to 0.
- R3: Each link's credit count starts at `CREDITS`. It falls by one per packet sent on the link and rises by one per `credit_ret_i` pulse. No packet is sent on a link whose count is zero.
- R4: A head-of-line packet blocked by zero credit stays in its FIFO. The port's pointer does not move, and the same central module is retried every slot until credit returns.
- R5: If several ports target the same link in one slot, the lowest-numbered port wins. Each losing port keeps its packet and retries the same module in the next slot. At most one packet is sent per link per slot.
- R6: A packet written at a clock edge into an empty FIFO, with credit and no conflict, appears on `link_valid_o`/`link_data_o` right after the following edge. A port can dispatch a packet in every slot.
- R7: While a FIFO holds `FIFO_DEPTH` packets, `in_ready_o` for that port is low. A write offered then is dropped without changing the FIFO contents, and `overflow_o` for that port is high for exactly the one cycle after that edge.
- R8: During and right after reset all links are idle, all FIFOs are empty, `in_ready_o` is all ones and `overflow_o` is all zeros.
- R9: A port with an empty FIFO never sends, so links stay idle when no packets are stored, even when credit is available.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; one cycle is one time slot |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid_i | input | PORTS | Per-port packet write strobe |
| in_data_i | input | PORTS*PKT_W | Per-port packet; port p at bits [p*PKT_W +: PKT_W] |
| in_ready_o | output | PORTS | Per-port FIFO has room |
| overflow_o | output | PORTS | One-cycle pulse after a write was dropped on a full FIFO |
| link_valid_o | output | PORTS | Link c carries a packet to central module c this cycle |
| link_data_o | output | PORTS*PKT_W | Packet on link c at bits [c*PKT_W +: PKT_W] |
| credit_ret_i | input | PORTS | Pulse returns one credit for link c |

## Verification
The bound checker tests several rules in every cycle. Each grant must follow the pointer sequence, and a pointer must not move unless its port was granted. Only one port may win a given link. A link's valid must match a grant in the cycle before. The overflow pulse must match a refused write, and the packets outstanding on a link may never exceed the credit depth. Some behaviour can only be shown by the bench scenarios: end-to-end packet order and content, the exact one-cycle latency, the priority order in a head-on conflict, a held packet going out on its own link once credit is returned, and dropped data never reaching a link.

// File: rtl/rrd_pkg.sv
package rrd_pkg;
  // Increment with wrap for round-robin indices.
  function automatic int unsigned wrap_inc(input int unsigned v, input int unsigned lim);
    return (v + 1 >= lim) ? 0 : v + 1;
  endfunction
endpackage

// File: rtl/rrd_fifo.sv
module rrd_fifo #(
  parameter int W     = 16,
  parameter int DEPTH = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_en,
  input  logic [W-1:0] wr_data,
  input  logic         rd_en,
  output logic [W-1:0] rd_data,
  output logic         empty,
  output logic         full,
  output logic         ovf
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wptr, rptr;
  logic [CW-1:0] count;
  logic          wr_acc, rd_acc;

  assign empty  = (count == '0);
  assign full   = (count == CW'(DEPTH));
  assign wr_acc = wr_en && !full;
  assign rd_acc = rd_en && !empty;
  assign rd_data = mem[rptr];

  always_ff @(posedge clk) begin
    if (wr_acc) mem[wptr] <= wr_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr  <= '0;
      rptr  <= '0;
      count <= '0;
      ovf   <= 1'b0;
    end else begin
      ovf <= wr_en && full;
      if (wr_acc) wptr <= (wptr == AW'(DEPTH - 1)) ? '0 : wptr + 1'b1;
      if (rd_acc) rptr <= (rptr == AW'(DEPTH - 1)) ? '0 : rptr + 1'b1;
      case ({wr_acc, rd_acc})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end
endmodule

// File: rtl/rrd_ptr.sv
module rrd_ptr #(
  parameter int LIM = 4,
  parameter int PW  = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          adv,
  output logic [PW-1:0] ptr
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ptr <= '0;
    else if (adv) ptr <= PW'(rrd_pkg::wrap_inc(int'(ptr), LIM));
  end
endmodule

// File: rtl/rrd_credit.sv
module rrd_credit #(
  parameter int CREDITS = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic take,
  input  logic give,
  output logic avail
);
  localparam int CW = $clog2(CREDITS + 1);
  logic [CW-1:0] cnt;

  assign avail = (cnt != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt <= CW'(CREDITS);
    else begin
      case ({take, give})
        2'b10:   cnt <= cnt - 1'b1;
        2'b01:   cnt <= (cnt == CW'(CREDITS)) ? cnt : cnt + 1'b1;
        default: cnt <= cnt;
      endcase
    end
  end
endmodule

// File: rtl/rrd_arb.sv
module rrd_arb #(
  parameter int PORTS = 4,
  parameter int PW    = 2
) (
  input  logic [PORTS-1:0]    req,
  input  logic [PORTS*PW-1:0] tgt,
  input  logic [PORTS-1:0]    avail,
  output logic [PORTS-1:0]    grant,
  output logic [PORTS-1:0]    lsel_v,
  output logic [PORTS*PW-1:0] lsel_p
);
  // Per link: first requesting port in index order wins, if credit exists.
  always_comb begin
    grant  = '0;
    lsel_v = '0;
    lsel_p = '0;
    for (int c = 0; c < PORTS; c++) begin
      for (int p = 0; p < PORTS; p++) begin
        if (!lsel_v[c] && req[p] && avail[c] && (tgt[p*PW +: PW] == PW'(c))) begin
          lsel_v[c]           = 1'b1;
          lsel_p[c*PW +: PW]  = PW'(p);
          grant[p]            = 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/rr_cm_dispatch.sv
module rr_cm_dispatch #(
  parameter int PORTS      = 4,
  parameter int PKT_W      = 16,
  parameter int FIFO_DEPTH = 4,
  parameter int CREDITS    = 2
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [PORTS-1:0]       in_valid_i,
  input  logic [PORTS*PKT_W-1:0] in_data_i,
  output logic [PORTS-1:0]       in_ready_o,
  output logic [PORTS-1:0]       overflow_o,
  output logic [PORTS-1:0]       link_valid_o,
  output logic [PORTS*PKT_W-1:0] link_data_o,
  input  logic [PORTS-1:0]       credit_ret_i
);
  localparam int PW = (PORTS > 1) ? $clog2(PORTS) : 1;

  logic [PORTS-1:0]    port_empty, port_full, port_req, port_grant;
  logic [PORTS*PW-1:0] port_tgt;
  logic [PKT_W-1:0]    head [PORTS];
  logic [PORTS-1:0]    cm_avail, lsel_v;
  logic [PORTS*PW-1:0] lsel_p;

  for (genvar p = 0; p < PORTS; p++) begin : g_port
    rrd_fifo #(.W(PKT_W), .DEPTH(FIFO_DEPTH)) u_fifo (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (in_valid_i[p]),
      .wr_data (in_data_i[p*PKT_W +: PKT_W]),
      .rd_en   (port_grant[p]),
      .rd_data (head[p]),
      .empty   (port_empty[p]),
      .full    (port_full[p]),
      .ovf     (overflow_o[p])
    );
    rrd_ptr #(.LIM(PORTS), .PW(PW)) u_ptr (
      .clk   (clk),
      .rst_n (rst_n),
      .adv   (port_grant[p]),
      .ptr   (port_tgt[p*PW +: PW])
    );
    assign port_req[p]   = !port_empty[p];
    assign in_ready_o[p] = !port_full[p];
  end

  for (genvar c = 0; c < PORTS; c++) begin : g_cm
    rrd_credit #(.CREDITS(CREDITS)) u_credit (
      .clk   (clk),
      .rst_n (rst_n),
      .take  (lsel_v[c]),
      .give  (credit_ret_i[c]),
      .avail (cm_avail[c])
    );
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        link_valid_o[c]                <= 1'b0;
        link_data_o[c*PKT_W +: PKT_W]  <= '0;
      end else begin
        link_valid_o[c] <= lsel_v[c];
        if (lsel_v[c]) link_data_o[c*PKT_W +: PKT_W] <= head[lsel_p[c*PW +: PW]];
      end
    end
  end

  rrd_arb #(.PORTS(PORTS), .PW(PW)) u_arb (
    .req    (port_req),
    .tgt    (port_tgt),
    .avail  (cm_avail),
    .grant  (port_grant),
    .lsel_v (lsel_v),
    .lsel_p (lsel_p)
  );
endmodule

// File: rtl/rr_cm_dispatch_chk.sv
module rr_cm_dispatch_chk #(
  parameter int PORTS   = 4,
  parameter int CREDITS = 2,
  parameter int PW      = 2
) (
  input logic                clk,
  input logic                rst_n,
  input logic [PORTS-1:0]    in_valid_i,
  input logic [PORTS-1:0]    in_ready_o,
  input logic [PORTS-1:0]    overflow_o,
  input logic [PORTS-1:0]    link_valid_o,
  input logic [PORTS-1:0]    credit_ret_i,
  input logic [PORTS-1:0]    port_grant,
  input logic [PORTS*PW-1:0] port_tgt
);
  logic [PORTS-1:0] hit [PORTS];
  logic [PW-1:0]    exp_t [PORTS];
  int               out_cnt [PORTS];

  always_comb begin
    for (int c = 0; c < PORTS; c++)
      for (int p = 0; p < PORTS; p++)
        hit[c][p] = port_grant[p] && (port_tgt[p*PW +: PW] == PW'(c));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int p = 0; p < PORTS; p++) exp_t[p] <= '0;
      for (int c = 0; c < PORTS; c++) out_cnt[c] <= 0;
    end else begin
      for (int p = 0; p < PORTS; p++)
        if (port_grant[p])
          exp_t[p] <= (port_tgt[p*PW +: PW] == PW'(PORTS - 1)) ? '0 : port_tgt[p*PW +: PW] + 1'b1;
      for (int c = 0; c < PORTS; c++) begin
        if (link_valid_o[c] && !(credit_ret_i[c] && out_cnt[c] > 0)) out_cnt[c] <= out_cnt[c] + 1;
        else if (!link_valid_o[c] && credit_ret_i[c] && out_cnt[c] > 0) out_cnt[c] <= out_cnt[c] - 1;
      end
    end
  end

  for (genvar p = 0; p < PORTS; p++) begin : g_pchk
    AST_ROTATE_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
      port_grant[p] |-> (port_tgt[p*PW +: PW] == exp_t[p])); // R2
    AST_HOLD_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
      !port_grant[p] |=> $stable(port_tgt[p*PW +: PW])); // R4
    AST_OVF_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
      overflow_o[p] |-> $past(in_valid_i[p] && !in_ready_o[p])); // R7
    AST_OVF_RAISED: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid_i[p] && !in_ready_o[p]) |=> overflow_o[p]); // R7
  end

  for (genvar c = 0; c < PORTS; c++) begin : g_cchk
    AST_ONE_WINNER: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(hit[c]) <= 1); // R5
    AST_LINK_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
      (|hit[c]) |=> link_valid_o[c]); // R6
    AST_LINK_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
      link_valid_o[c] |-> $past(|hit[c])); // R9
    AST_CREDIT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      out_cnt[c] <= CREDITS); // R3
  end
endmodule

bind rr_cm_dispatch rr_cm_dispatch_chk #(.PORTS(PORTS), .CREDITS(CREDITS), .PW(PW)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .in_valid_i   (in_valid_i),
  .in_ready_o   (in_ready_o),
  .overflow_o   (overflow_o),
  .link_valid_o (link_valid_o),
  .credit_ret_i (credit_ret_i),
  .port_grant   (port_grant),
  .port_tgt     (port_tgt)
);

// File: tb/rr_cm_dispatch_test.sv
`timescale 1ns/1ps
module rr_cm_dispatch_test;
  localparam int P = 4;
  localparam int W = 16;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic [P-1:0]   in_valid_i = '0;
  logic [P*W-1:0] in_data_i = '0;
  logic [P-1:0]   in_ready_o, overflow_o, link_valid_o, credit_ret_i;
  logic [P*W-1:0] link_data_o;
  logic [P-1:0]   man_ret = '0;
  logic [P-1:0]   ret_q = '0;
  bit             auto_ret = 1'b1;
  bit             done = 1'b0;

  int n_chk = 0;
  int n_fail = 0;
  int mptr [P];
  logic [W-1:0] exp_q [P][$];

  always #2 clk = ~clk;

  assign credit_ret_i = man_ret | ret_q;

  rr_cm_dispatch #(.PORTS(P), .PKT_W(W), .FIFO_DEPTH(4), .CREDITS(2)) uut (
    .clk(clk), .rst_n(rst_n), .in_valid_i(in_valid_i), .in_data_i(in_data_i),
    .in_ready_o(in_ready_o), .overflow_o(overflow_o), .link_valid_o(link_valid_o),
    .link_data_o(link_data_o), .credit_ret_i(credit_ret_i)
  );

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // Monitor / scoreboard
  always @(negedge clk) begin
    if (rst_n) begin
      for (int c = 0; c < P; c++) begin
        if (link_valid_o[c]) begin
          if (exp_q[c].size() == 0)
            chk(1'b0, "R1 R2 unexpected packet", {48'd0, link_data_o[c*W +: W]}, 64'hdead);
          else begin
            logic [W-1:0] e;
            e = exp_q[c].pop_front();
            chk(link_data_o[c*W +: W] == e, "R1 R2 scoreboard", {48'd0, link_data_o[c*W +: W]}, {48'd0, e});
          end
        end
      end
    end
    ret_q <= auto_ret ? link_valid_o : '0;
  end

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic send(input logic [P-1:0] mask, input logic [P*W-1:0] data, input bit drop);
    for (int p = 0; p < P; p++) begin
      if (mask[p]) begin
        in_valid_i[p] = 1'b1;
        in_data_i[p*W +: W] = data[p*W +: W];
        if (!drop) begin
          exp_q[mptr[p]].push_back(data[p*W +: W]);
          mptr[p] = (mptr[p] + 1) % P;
        end
      end
    end
    tick();
    in_valid_i = '0;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    in_valid_i = '0;
    man_ret = '0;
    for (int p = 0; p < P; p++) begin
      mptr[p] = 0;
      exp_q[p].delete();
    end
    repeat (2) tick();
    rst_n = 1'b1;
    tick();
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    do_reset();
    @(negedge clk);
    chk(link_valid_o == '0, "R8 links idle", {60'd0, link_valid_o}, 0);
    chk(in_ready_o == '1, "R8 ready", {60'd0, in_ready_o}, 64'hf);
    chk(overflow_o == '0, "R8 no overflow", {60'd0, overflow_o}, 0);

    // R6: latency of one slot after the write edge
    tick();
    send(4'b0001, {48'd0, 16'hA001}, 1'b0);
    @(negedge clk);
    chk(link_valid_o == '0, "R6 not yet", {60'd0, link_valid_o}, 0);
    tick();
    @(negedge clk);
    chk(link_valid_o == 4'b0001, "R6 on link0", {60'd0, link_valid_o}, 1);
    chk(link_data_o[15:0] == 16'hA001, "R6 data", {48'd0, link_data_o[15:0]}, 64'hA001);

    // R2 R6: back-to-back stream on port 0 rotates 1,2,3,0,1
    tick();
    for (int i = 0; i < 5; i++) send(4'b0001, {48'd0, 16'hB000 + 16'(i)}, 1'b0);
    repeat (4) tick();
    for (int c = 0; c < P; c++) chk(exp_q[c].size() == 0, "R2 stream drained", 64'(exp_q[c].size()), 0);

    // R5: ports 0 and 1 both aim at module 0
    do_reset();
    send(4'b0011, {32'd0, 16'hC111, 16'hC000}, 1'b0);
    tick();
    @(negedge clk);
    chk(link_valid_o == 4'b0001 && link_data_o[15:0] == 16'hC000, "R5 low index first",
        {44'd0, link_valid_o, link_data_o[15:0]}, {44'd0, 4'b0001, 16'hC000});
    tick();
    @(negedge clk);
    chk(link_valid_o == 4'b0001 && link_data_o[15:0] == 16'hC111, "R5 loser retries same module",
        {44'd0, link_valid_o, link_data_o[15:0]}, {44'd0, 4'b0001, 16'hC111});

    // R3 R4: three ports on module 0 with two credits and no returns
    do_reset();
    auto_ret = 1'b0;
    send(4'b0111, {16'd0, 16'hD222, 16'hD111, 16'hD000}, 1'b0);
    repeat (6) tick();
    chk(exp_q[0].size() == 1, "R3 only two sends without credit", 64'(exp_q[0].size()), 1);
    @(negedge clk);
    chk(link_valid_o == '0, "R4 held while blocked", {60'd0, link_valid_o}, 0);
    chk(in_ready_o[2] == 1'b1, "R4 packet kept, not full", {63'd0, in_ready_o[2]}, 1);
    tick();
    man_ret = 4'b0001;
    tick();
    man_ret = '0;
    repeat (3) tick();
    chk(exp_q[0].size() == 0, "R4 retried module 0 after credit", 64'(exp_q[0].size()), 0);

    // R7: fill port 0 and overflow it
    do_reset();
    auto_ret = 1'b0;
    for (int i = 0; i < 12; i++) send(4'b0001, {48'd0, 16'hE000 + 16'(i)}, 1'b0);
    @(negedge clk);
    chk(in_ready_o[0] == 1'b0, "R7 ready low when full", {63'd0, in_ready_o[0]}, 0);
    tick();
    send(4'b0001, {48'd0, 16'hEEEE}, 1'b1);
    @(negedge clk);
    chk(overflow_o == 4'b0001, "R7 overflow pulse", {60'd0, overflow_o}, 1);
    tick();
    @(negedge clk);
    chk(overflow_o == '0, "R7 pulse one cycle", {60'd0, overflow_o}, 0);
    tick();
    man_ret = 4'b1111;
    tick();
    man_ret = '0;
    repeat (8) tick();
    for (int c = 0; c < P; c++) chk(exp_q[c].size() == 0, "R1 order kept after overflow", 64'(exp_q[c].size()), 0);

    // R9: empty FIFOs with credit stay silent
    auto_ret = 1'b1;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      chk(link_valid_o == '0, "R9 idle when empty", {60'd0, link_valid_o}, 0);
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule